// File: doc/BRIEF.md
# Converter Serial Port Controller

This block is the device-side serial port of a delta-sigma converter. A host drives chip select, serial clock and data in, and the block answers on data out. Byte commands switch between two read modes, fetch a single conversion on request, and read or write a small configuration register file. Conversion words come from the converter core on a one-cycle valid strobe with a 24-bit two's complement word. A data-ready output goes low when a new word is waiting and returns high once a read of it starts.

All serial inputs are sampled on the system clock, so the serial clock must be several system clocks per phase. Data in is taken on the serial clock rising edge, and data out moves on the falling edge, MSB first. The port leaves continuous read after a stop command. Until it does, register commands are dropped. The shift and decode state falls back to idle when chip select goes high, when the soft reset input is pulsed, or when the serial clock has stayed idle for a fixed number of conversion periods during continuous read.

Top module: `cspc_port`

## Requirements
- R1: After rst_ni low or a one-cycle srst_i pulse, the port is in continuous read mode, drdy_no is 1 and every register holds its reset value. dout_o is 0 whenever chip select is high.
- R2: The register file has addresses 00h to 0Ah. Address 00h always reads ID_CODE (30h by default) and ignores writes. Reset values are 01h=52h, 02h=08h, 03h=32h, 04h=03h and 0Ah=40h, and the rest are 00h. Writes above 0Ah are dropped, and reads above 0Ah return 00h.
- R3: In continuous read mode, a conv_valid_i pulse drives drdy_no low on the next clock. It also puts the new word on dout_o, MSB first, before the first serial clock rise. drdy_no returns to 1 on the first serial clock rise.
- R4: In command read mode, a new conversion is not shifted out until opcode 12h is received. Each 12h presents the latest word once and sets drdy_no to 1. After the 24 bits, dout_o shifts zeros.
- R5: Opcode 10h selects continuous read mode and opcode 11h selects command read mode. Byte 00h is a no-op.
- R6: Opcode 20h+a, followed by a byte n, returns n+1 register bytes from consecutive addresses starting at a, one per following byte.
- R7: Opcode 40h+a, followed by a byte n, writes the next n+1 bytes to consecutive addresses starting at a.
- R8: While continuous read mode is active, register read and write opcodes are ignored and the register contents do not change.
- R9: Chip select high clears a partly received byte and any open command. The next byte after chip select returns low is decoded as an opcode.
- R10: In continuous read mode, if IDLE_PERIODS (64) conversions arrive with no serial clock rise, the shift and decode state returns to idle.
- R11: Data in is sampled on the serial clock rising edge. dout_o holds its value across the rise and changes only after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous soft reset pulse (port and registers) |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |
| drdy_no | output | 1 | Data ready, low when a new word is waiting |
| conv_valid_i | input | 1 | One-cycle strobe for a new conversion |
| conv_data_i | input | 24 | Conversion word, two's complement |

## Verification
Some properties are checked on every cycle: data-ready falling after each conversion strobe, the soft reset restoring the mode and data-ready, the register file staying frozen in continuous mode, and the shift state clearing after a chip-select deselect or an idle timeout. Other behaviour depends on whole byte sequences, so only the bench scenarios can show it. This covers opcode decoding, group writes read back across the file, word alignment on dout, one word per read command, and recovery from a misaligned partial byte through a deselect or through 64 silent conversion periods.

// File: rtl/cspc_pkg.sv
package cspc_pkg;
  localparam int ADDR_W = 5;

  localparam logic [7:0] OP_RDATAC = 8'h10;
  localparam logic [7:0] OP_SDATAC = 8'h11;
  localparam logic [7:0] OP_RDATA  = 8'h12;
  localparam logic [2:0] OP_RREG_HI = 3'b001;
  localparam logic [2:0] OP_WREG_HI = 3'b010;

  typedef enum logic [1:0] {ST_OP, ST_CNT, ST_RD, ST_WR} st_e;

  function automatic logic [7:0] reg_rst(int idx);
    case (idx)
      1:  return 8'h52;
      2:  return 8'h08;
      3:  return 8'h32;
      4:  return 8'h03;
      10: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cspc_sync.sv
module cspc_sync #(
  parameter int         WIDTH   = 3,
  parameter int         STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cspc_edge.sv
module cspc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/cspc_regfile.sv
module cspc_regfile
  import cspc_pkg::*;
#(
  parameter int         NUM_REGS = 11,
  parameter logic [7:0] ID_CODE  = 8'h30
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  srst_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [ADDR_W-1:0]     raddr_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  assign regs_o[7:0] = ID_CODE;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 val_q <= reg_rst(g);
      else if (srst_i)                             val_q <= reg_rst(g);
      else if (we_i && waddr_i == ADDR_W'(g))      val_q <= wdata_i;
    end
    assign regs_o[g*8 +: 8] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = regs_o[i*8 +: 8];
  end
endmodule

// File: rtl/cspc_idle_timer.sv
module cspc_idle_timer #(
  parameter int PERIODS = 64,
  localparam int CW = $clog2(PERIODS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic          fire_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign fire_o = en_i & ~clr_i & tick_i & (cnt_q == CW'(PERIODS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || fire_o) cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cspc_port.sv
module cspc_port
  import cspc_pkg::*;
#(
  parameter int         CONV_W       = 24,
  parameter int         NUM_REGS     = 11,
  parameter int         SYNC_STAGES  = 2,
  parameter int         IDLE_PERIODS = 64,
  parameter logic [7:0] ID_CODE      = 8'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              drdy_no,
  input  logic              conv_valid_i,
  input  logic [CONV_W-1:0] conv_data_i
);
  localparam int PAD_W   = CONV_W - 8;
  localparam int IDLE_CW = $clog2(IDLE_PERIODS + 1);

  logic cs_s, sclk_s, din_s, sclk_rise, sclk_fall;

  cspc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sclk_i, din_i}), .q_o({cs_s, sclk_s, din_s})
  );

  cspc_edge i_sclk_edge (
    .clk_i, .rst_ni, .lvl_i(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  logic              mode_cont_q, mode_d;
  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, raddr;
  logic [7:0]        rem_q, rem_d;
  logic              wr_q, wr_d;
  logic [2:0]        bit_cnt_q;
  logic [6:0]        rx_q;
  logic [7:0]        rx_byte, rd_data;
  logic [CONV_W-1:0] tx_q, conv_q, pend_val_q, load_val;
  logic              pend_q, load_req, rdata_go, we;
  logic              idle_fire;
  logic [IDLE_CW-1:0] idle_cnt;
  logic [NUM_REGS*8-1:0] regs_flat;

  logic act_rise, act_fall, port_clr, byte_done;
  assign act_rise  = sclk_rise & ~cs_s;
  assign act_fall  = sclk_fall & ~cs_s;
  assign port_clr  = cs_s | idle_fire | srst_i;
  assign byte_done = act_rise & (bit_cnt_q == 3'd7) & ~idle_fire & ~srst_i;
  assign rx_byte   = {rx_q, din_s};
  assign raddr     = (st_q == ST_RD) ? addr_q + ADDR_W'(1) : addr_q;

  cspc_regfile #(.NUM_REGS(NUM_REGS), .ID_CODE(ID_CODE)) i_regs (
    .clk_i, .rst_ni, .srst_i,
    .we_i(we), .waddr_i(addr_q), .wdata_i(rx_byte),
    .raddr_i(raddr), .rdata_o(rd_data), .regs_o(regs_flat)
  );

  cspc_idle_timer #(.PERIODS(IDLE_PERIODS)) i_idle (
    .clk_i, .rst_ni,
    .en_i(mode_cont_q), .clr_i(sclk_rise | ~mode_cont_q | srst_i),
    .tick_i(conv_valid_i), .fire_o(idle_fire), .cnt_o(idle_cnt)
  );

  // command decoder, acts once per completed byte
  always_comb begin
    st_d     = st_q;
    mode_d   = mode_cont_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    wr_d     = wr_q;
    load_req = 1'b0;
    load_val = '0;
    rdata_go = 1'b0;
    we       = 1'b0;
    if (byte_done) begin
      case (st_q)
        ST_OP: begin
          if (rx_byte == OP_RDATAC) mode_d = 1'b1;
          else if (rx_byte == OP_SDATAC) mode_d = 1'b0;
          else if (!mode_cont_q) begin
            if (rx_byte == OP_RDATA) begin
              load_req = 1'b1;
              load_val = conv_q;
              rdata_go = 1'b1;
            end else if (rx_byte[7:5] == OP_RREG_HI || rx_byte[7:5] == OP_WREG_HI) begin
              addr_d = rx_byte[ADDR_W-1:0];
              wr_d   = rx_byte[6];
              st_d   = ST_CNT;
            end
          end
        end
        ST_CNT: begin
          rem_d = rx_byte;
          if (wr_q) st_d = ST_WR;
          else begin
            st_d     = ST_RD;
            load_req = 1'b1;
            load_val = {rd_data, PAD_W'(0)};
          end
        end
        ST_RD: begin
          if (rem_q == 8'd0) st_d = ST_OP;
          else begin
            rem_d    = rem_q - 8'd1;
            addr_d   = addr_q + ADDR_W'(1);
            load_req = 1'b1;
            load_val = {rd_data, PAD_W'(0)};
          end
        end
        ST_WR: begin
          we = 1'b1;
          if (rem_q == 8'd0) st_d = ST_OP;
          else begin
            rem_d  = rem_q - 8'd1;
            addr_d = addr_q + ADDR_W'(1);
          end
        end
        default: st_d = ST_OP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else if (port_clr) begin
      bit_cnt_q <= '0;
    end else if (act_rise) begin
      bit_cnt_q <= bit_cnt_q + 3'd1;
      rx_q      <= {rx_q[5:0], din_s};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OP;
      addr_q <= '0;
      rem_q  <= '0;
      wr_q   <= 1'b0;
    end else if (port_clr) begin
      st_q <= ST_OP;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      wr_q   <= wr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_cont_q <= 1'b1;
    else if (srst_i) mode_cont_q <= 1'b1;
    else             mode_cont_q <= mode_d;
  end

  // transmit load is deferred to the next falling edge so the first bit is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (port_clr) begin
      pend_q <= 1'b0;
    end else if (load_req) begin
      pend_q     <= 1'b1;
      pend_val_q <= load_val;
    end else if (act_fall) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tx_q <= '0;
    else if (srst_i)                      tx_q <= '0;
    else if (conv_valid_i && mode_cont_q) tx_q <= conv_data_i;
    else if (act_fall)                    tx_q <= pend_q ? pend_val_q : {tx_q[CONV_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q  <= '0;
      drdy_no <= 1'b1;
    end else if (srst_i) begin
      conv_q  <= '0;
      drdy_no <= 1'b1;
    end else if (conv_valid_i) begin
      conv_q  <= conv_data_i;
      drdy_no <= 1'b0;
    end else if ((mode_cont_q && act_rise) || rdata_go) begin
      drdy_no <= 1'b1;
    end
  end

  assign dout_o = tx_q[CONV_W-1] & ~cs_s;
endmodule

// File: rtl/cspc_port_chk.sv
module cspc_port_chk
  import cspc_pkg::*;
#(
  parameter int NUM_REGS     = 11,
  parameter int IDLE_PERIODS = 64,
  parameter int CW           = 7
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  srst_i,
  input logic                  conv_valid_i,
  input logic                  drdy_no,
  input logic                  mode_cont,
  input logic [NUM_REGS*8-1:0] regs,
  input logic                  idle_fire,
  input logic [CW-1:0]         idle_cnt,
  input logic [2:0]            bit_cnt,
  input st_e                   st,
  input logic                  cs_s
);
  assert_drdy_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_valid_i && !srst_i |=> !drdy_no);

  assert_soft_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> drdy_no && mode_cont);

  assert_reg_guard_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_cont && !srst_i |=> $stable(regs));

  assert_idle_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_fire |=> bit_cnt == 3'd0 && st == ST_OP);

  assert_idle_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cnt < CW'(IDLE_PERIODS));

  assert_cs_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> bit_cnt == 3'd0 && st == ST_OP);
endmodule

bind cspc_port cspc_port_chk #(
  .NUM_REGS(NUM_REGS), .IDLE_PERIODS(IDLE_PERIODS), .CW(IDLE_CW)
) i_cspc_port_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .conv_valid_i(conv_valid_i),
  .drdy_no(drdy_no), .mode_cont(mode_cont_q), .regs(regs_flat),
  .idle_fire(idle_fire), .idle_cnt(idle_cnt), .bit_cnt(bit_cnt_q),
  .st(st_q), .cs_s(cs_s)
);

// File: tb/test_cspc_port.sv
module test_cspc_port;
  logic clk = 1'b0, rst_n = 1'b0, srst = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, cv = 1'b0;
  logic [23:0] cd = '0;
  logic dout, drdy_n;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] mregs [0:31];

  always #5ns clk = ~clk;

  cspc_port i_cspc_port (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .cs_ni(cs_n), .sclk_i(sclk),
    .din_i(din), .dout_o(dout), .drdy_no(drdy_n), .conv_valid_i(cv), .conv_data_i(cd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mregs[i] = 8'h00;
    mregs[0] = 8'h30; mregs[1] = 8'h52; mregs[2] = 8'h08;
    mregs[3] = 8'h32; mregs[4] = 8'h03; mregs[10] = 8'h40;
  endtask

  task automatic sbit(input logic b, output logic r);
    din = b;
    wait_clks(6);
    r = dout;
    sclk = 1'b1;
    wait_clks(6);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
    wait_clks(6);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, r);
  endtask

  task automatic read24(output logic [23:0] w);
    logic [7:0] r;
    for (int k = 2; k >= 0; k--) begin
      xfer(8'h00, r);
      w[k*8 +: 8] = r;
    end
  endtask

  task automatic conv(input logic [23:0] w);
    @(negedge clk);
    cv = 1'b1; cd = w;
    @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic rreg(input int a, input int n, input string tag);
    logic [7:0] r;
    send(8'h20 | 8'(a));
    send(8'(n - 1));
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(tag, {24'h0, r}, {24'h0, (a + k <= 10) ? mregs[a + k] : 8'h00});
    end
  endtask

  task automatic mwr(input int a, input logic [7:0] v);
    if (a >= 1 && a <= 10) mregs[a] = v;
  endtask

  initial begin
    logic [23:0] w;
    logic b;
    model_reset();
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(5);

    // R1: reset state
    chk("R1 drdy after reset", drdy_n, 1);
    chk("R1 dout with cs high", dout, 0);
    cs_n = 1'b0;
    wait_clks(8);

    // R3: continuous read of a new word
    conv(24'hA53C7E);
    wait_clks(2);
    chk("R3 drdy low after conversion", drdy_n, 0);
    read24(w);
    chk("R3 continuous word", w, 24'hA53C7E);
    chk("R3 drdy high after read start", drdy_n, 1);

    // R8: register write ignored in continuous mode
    send(8'h41); send(8'h00); send(8'h55);
    send(8'h11);
    rreg(1, 1, "R8 guarded write left reg 01h");

    // R2 R6: reset values and ID read as one group
    rreg(0, 11, "R2 R6 reset values");

    // R7: group write and readback
    send(8'h41); send(8'h02);
    send(8'hA1); mwr(1, 8'hA1);
    send(8'hB2); mwr(2, 8'hB2);
    send(8'hC3); mwr(3, 8'hC3);
    rreg(1, 3, "R7 group write readback");

    // R2: read-only ID, writes beyond the top dropped
    send(8'h4A); send(8'h01);
    send(8'h5A); mwr(10, 8'h5A);
    send(8'h77);
    send(8'h40); send(8'h00); send(8'hFF);
    rreg(0, 12, "R2 ID and out-of-range");

    // R4: command mode needs 12h for each result
    conv(24'h13579B);
    wait_clks(2);
    chk("R4 drdy low in command mode", drdy_n, 0);
    read24(w);
    chk("R4 no word without command", w, 24'h000000);
    send(8'h12);
    chk("R4 drdy high after read command", drdy_n, 1);
    read24(w);
    chk("R4 word after read command", w, 24'h13579B);
    read24(w);
    chk("R4 word given only once", w, 24'h000000);

    // R5: back to continuous mode
    send(8'h10);
    conv(24'h800001);
    read24(w);
    chk("R5 continuous mode restored", w, 24'h800001);

    // R11: dout moves only after the falling edge
    conv(24'h5A5A5A);
    din = 1'b0;
    wait_clks(6);
    chk("R11 MSB before rise", dout, 0);
    sclk = 1'b1;
    wait_clks(6);
    chk("R11 dout held across rise", dout, 0);
    sclk = 1'b0;
    wait_clks(6);
    chk("R11 next bit after fall", dout, 1);

    // R9: chip select toggle realigns after a partial byte
    sbit(1'b1, b); sbit(1'b1, b); sbit(1'b1, b);
    cs_n = 1'b1;
    wait_clks(10);
    chk("R9 dout low while deselected", dout, 0);
    cs_n = 1'b0;
    wait_clks(8);
    send(8'h11);
    rreg(2, 1, "R9 decode after deselect");

    // R10: idle timeout after 64 silent conversions
    send(8'h10);
    sbit(1'b1, b); sbit(1'b1, b); sbit(1'b1, b);
    wait_clks(6);
    for (int i = 0; i < 64; i++) begin
      conv(24'(i));
      wait_clks(2);
    end
    send(8'h11);
    rreg(3, 1, "R10 decode after idle timeout");

    // R1: soft reset reloads registers and mode
    @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    model_reset();
    wait_clks(4);
    chk("R1 drdy after soft reset", drdy_n, 1);
    send(8'h41); send(8'h00); send(8'h99);
    send(8'h11);
    rreg(1, 3, "R1 R8 values after soft reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule